// File: doc/BRIEF.md
# Clock Pair Generator

This block produces one pair of clock outputs from two slower source clocks: a PLL output and a reference clock. Both arrive as level waveforms that are synchronous to a faster core clock. A 3-bit code selects the output behaviour. The pair can follow the reference unchanged, follow the chosen source at ratio 1, divide it by a fixed ratio of 2, 3 or 4, divide it by a programmable ratio X or 2X, or show the PLL lock flag as a static level. A separate control picks which source clock feeds the dividers.

The first output of the pair can be inverted to form a complementary pair. The second output always carries the true signal. Each output has its own output-enable, gated by a pair-level enable, for a pad that goes to high impedance when the enable is low. A new code, ratio or divider source is only taken up at the end of a complete output period, so a change never cuts a pulse short. The block makes no assumption about the phase of the source clocks, except that each source level is held for at least one core cycle.

Top module: `clkpair_gen`

## Requirements
- R1: While `rst_n` is low, all four outputs (`clk_a_o`, `clk_b_o`, `oe_a_o`, `oe_b_o`) are 0 from the first core clock edge after reset is asserted.
- R2: With code 3'b000, `clk_b_o` equals the reference level sampled one core edge earlier, whatever the divider-source control is set to.
- R3: With code 3'b001, `clk_b_o` equals the level of the selected source one core edge earlier. `div_from_ref_i` = 0 selects the PLL clock and 1 selects the reference clock.
- R4: Codes 3'b010, 3'b011 and 3'b100 divide the selected source by 2, 3 and 4. Each period is high for floor(n/2) source periods and low for the rest. A period starts at the core edge where the source rises, and the output changes only after a source rising edge.
- R5: Code 3'b101 divides by max(v,2)+3, where v is the 7-bit `x_ratio_i`, so the ratio covers 5 to 130. Code 3'b110 divides by twice that value. The duty cycle rule is the same as in R4, and the internal count always stays below the active ratio.
- R6: With code 3'b111, `clk_b_o` is a static copy of `pll_lock_i`, delayed by one core edge.
- R7: When `invert_i` is 1, `clk_a_o` is the complement of `clk_b_o`, including in lock mode (first output low and second high while locked). When `invert_i` is 0, the two outputs are equal.
- R8: `oe_a_o` equals `pair_en_i & en_a_i` and `oe_b_o` equals `pair_en_i & en_b_i`, each one core edge later. Disabling an output does not stop or restart its clock.
- R9: While a dividing code (3'b010 to 3'b110) is active, a change of code, X or divider source takes effect only at the edge that ends the current output period. Other codes take a new setting on the next core edge.
- R10: The divider count restarts at zero in reset. A dividing output is therefore high from the first core edge after release, and stays high until floor(n/2) source rising edges have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, faster than both sources |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_clk_i | input | 1 | PLL output clock level, synchronous to `clk` |
| ref_clk_i | input | 1 | Reference clock level, synchronous to `clk` |
| pll_lock_i | input | 1 | PLL lock flag |
| sel_i | input | 3 | Output source code |
| div_from_ref_i | input | 1 | Divider source: 0 PLL, 1 reference |
| x_ratio_i | input | 7 | Programmable ratio field v |
| invert_i | input | 1 | Invert the first output of the pair |
| pair_en_i | input | 1 | Pair-level output enable |
| en_a_i | input | 1 | Enable for the first output |
| en_b_i | input | 1 | Enable for the second output |
| clk_a_o | output | 1 | First clock output (optionally inverted) |
| clk_b_o | output | 1 | Second clock output (always true) |
| oe_a_o | output | 1 | Drive enable for the first output pad |
| oe_b_o | output | 1 | Drive enable for the second output pad |

## Verification
A wrong divider count shows up as a high or low run of the wrong length on `clk_b_o`. It appears within one output period of the fault, which is at most 260 source periods for the largest 2X setting. A wrongly latched configuration, or one taken up before its terminal count, changes the length of the current period. The per-cycle comparison catches that on the first core edge where the expected level differs. Faults in inversion, enable or lock routing show on the next core edge, because those paths pass through a single register.

// File: rtl/clkpair_pkg.sv
// Shared definitions for the clock pair generator.
// Assumes: the output source code is 3 bits wide and its values are fixed by behaviour.
package clkpair_pkg;

    // Output source code of one pair
    typedef enum logic [2:0] {
        SEL_REF  = 3'b000,
        SEL_DIV1 = 3'b001,
        SEL_DIV2 = 3'b010,
        SEL_DIV3 = 3'b011,
        SEL_DIV4 = 3'b100,
        SEL_DIVX = 3'b101,
        SEL_DIV2X = 3'b110,
        SEL_LOCK = 3'b111
    } pair_sel_e;

    // Fixed ratios for the three hard-wired dividers
    localparam int RATIO_TWO   = 2;
    localparam int RATIO_THREE = 3;
    localparam int RATIO_FOUR  = 4;

    // Programmable ratio: field value clamped to a floor, then offset
    localparam int X_FIELD_FLOOR = 2;
    localparam int X_OFFSET      = 3;

    // Number of source clocks that feed the pair
    localparam int NUM_SRC = 2;
    localparam int SRC_PLL = 0;
    localparam int SRC_REF = 1;

endpackage

// File: rtl/clkpair_edge.sv
// Rising-edge detector for the source clock levels.
// Assumes: each source level is synchronous to clk and holds for at least one
// core cycle. The previous level is cleared in reset, so a source that is high
// at release counts as one rising edge.
module clkpair_edge #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] lvl_i,
    output logic [NSRC-1:0] rise_o
);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic prev_q;

        // Purpose: keep the level seen at the previous core edge
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
            end else begin
                prev_q <= lvl_i[g];
            end
        end

        assign rise_o[g] = lvl_i[g] & ~prev_q;
    end

endmodule

// File: rtl/clkpair_ratio.sv
// Ratio decoder: turns an output source code and the X field into a division
// ratio, the length of the high phase, and a flag for codes that count.
// Assumes: non-counting codes report ratio 1, so that count zero is terminal.
module clkpair_ratio
    import clkpair_pkg::*;
#(
    parameter int XW = 7,
    parameter int CW = XW + 2
) (
    input  pair_sel_e       sel_i,
    input  logic [XW-1:0]   x_i,
    output logic [CW-1:0]   ratio_o,
    output logic [CW-1:0]   high_o,
    output logic            counting_o
);

    localparam logic [XW-1:0] X_FLOOR = XW'(X_FIELD_FLOOR);

    logic [XW-1:0] x_eff;
    logic [CW-1:0] x_ratio;

    // Purpose: clamp the field and add the offset for the X ratio
    always_comb begin
        x_eff   = (x_i < X_FLOOR) ? X_FLOOR : x_i;
        x_ratio = CW'(x_eff) + CW'(X_OFFSET);
    end

    // Purpose: pick the ratio of the active code
    always_comb begin
        counting_o = 1'b1;
        case (sel_i)
            SEL_DIV2:  ratio_o = CW'(RATIO_TWO);
            SEL_DIV3:  ratio_o = CW'(RATIO_THREE);
            SEL_DIV4:  ratio_o = CW'(RATIO_FOUR);
            SEL_DIVX:  ratio_o = x_ratio;
            SEL_DIV2X: ratio_o = x_ratio << 1;
            default: begin
                ratio_o    = CW'(1);
                counting_o = 1'b0;
            end
        endcase
    end

    // Purpose: high phase covers floor(ratio/2) source periods
    assign high_o = ratio_o >> 1;

endmodule

// File: rtl/clkpair_div.sv
// Divider core: holds the active configuration and the source-period count,
// and produces the pair's true signal for the next core edge.
// Assumes: a new configuration is loaded only at a terminal count. Codes that
// do not count reach a terminal count on every core edge.
module clkpair_div
    import clkpair_pkg::*;
#(
    parameter int XW = 7,
    parameter int CW = XW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pair_sel_e       cfg_sel_i,
    input  logic            cfg_from_ref_i,
    input  logic [XW-1:0]   cfg_x_i,
    input  logic [NUM_SRC-1:0] lvl_i,
    input  logic [NUM_SRC-1:0] rise_i,
    input  logic            lock_i,
    output logic            sig_o,
    output pair_sel_e       act_sel_o,
    output logic            counting_o,
    output logic            src_rise_o,
    output logic            boundary_o,
    output logic [CW-1:0]   cnt_o,
    output logic [CW-1:0]   ratio_o
);

    pair_sel_e     act_sel_q;
    logic          act_from_ref_q;
    logic [XW-1:0] act_x_q;
    logic [CW-1:0] cnt_q;

    logic [CW-1:0] ratio;
    logic [CW-1:0] high_len;
    logic          counting;
    logic          src_lvl;
    logic          src_rise;
    logic          last;
    logic [CW-1:0] cnt_step;
    logic          boundary;
    logic [CW-1:0] cnt_seen;

    clkpair_ratio #(.XW(XW), .CW(CW)) u_ratio (
        .sel_i      (act_sel_q),
        .x_i        (act_x_q),
        .ratio_o    (ratio),
        .high_o     (high_len),
        .counting_o (counting)
    );

    // Purpose: choose the active divider source and find the terminal count
    always_comb begin
        src_lvl  = act_from_ref_q ? lvl_i[SRC_REF]  : lvl_i[SRC_PLL];
        src_rise = act_from_ref_q ? rise_i[SRC_REF] : rise_i[SRC_PLL];
        last     = (cnt_q == ratio - CW'(1));
        cnt_step = last ? '0 : cnt_q + CW'(1);
        boundary = !counting || (src_rise && last);
        cnt_seen = src_rise ? cnt_step : cnt_q;
    end

    // Purpose: load configuration at terminal count, otherwise advance on source rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel_q      <= cfg_sel_i;
            act_from_ref_q <= cfg_from_ref_i;
            act_x_q        <= cfg_x_i;
            cnt_q          <= '0;
        end else if (boundary) begin
            act_sel_q      <= cfg_sel_i;
            act_from_ref_q <= cfg_from_ref_i;
            act_x_q        <= cfg_x_i;
            cnt_q          <= '0;
        end else if (src_rise) begin
            cnt_q          <= cnt_step;
        end
    end

    // Purpose: true signal of the pair under the active code
    always_comb begin
        case (act_sel_q)
            SEL_REF:  sig_o = lvl_i[SRC_REF];
            SEL_DIV1: sig_o = src_lvl;
            SEL_LOCK: sig_o = lock_i;
            default:  sig_o = (cnt_seen < high_len);
        endcase
    end

    assign act_sel_o  = act_sel_q;
    assign counting_o = counting;
    assign src_rise_o = src_rise;
    assign boundary_o = boundary;
    assign cnt_o      = cnt_q;
    assign ratio_o    = ratio;

endmodule

// File: rtl/clkpair_out.sv
// Output stage: registers both outputs of the pair together with their
// drive enables, so that levels and enables change on the same edge.
// Assumes: lane 0 is the first output (which can be inverted) and lane 1
// is the second output (always true).
module clkpair_out #(
    parameter int NLANE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_i,
    input  logic [NLANE-1:0] inv_i,
    input  logic             pair_en_i,
    input  logic [NLANE-1:0] en_i,
    output logic [NLANE-1:0] clk_o,
    output logic [NLANE-1:0] oe_o
);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic clk_q;
        logic oe_q;

        // Purpose: register lane level (polarity applied) and its enable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                clk_q <= 1'b0;
                oe_q  <= 1'b0;
            end else begin
                clk_q <= sig_i ^ inv_i[g];
                oe_q  <= pair_en_i & en_i[g];
            end
        end

        assign clk_o[g] = clk_q;
        assign oe_o[g]  = oe_q;
    end

endmodule

// File: rtl/clkpair_gen.sv
// Clock pair generator top: edge detection on the two source clocks,
// divider core with terminal-count reload, and a registered output stage.
// Assumes: both source levels are synchronous to clk and slower than it.
// Three-stating is done at the pad, from the oe outputs.
module clkpair_gen
    import clkpair_pkg::*;
#(
    parameter int XW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pll_clk_i,
    input  logic          ref_clk_i,
    input  logic          pll_lock_i,
    input  logic [2:0]    sel_i,
    input  logic          div_from_ref_i,
    input  logic [XW-1:0] x_ratio_i,
    input  logic          invert_i,
    input  logic          pair_en_i,
    input  logic          en_a_i,
    input  logic          en_b_i,
    output logic          clk_a_o,
    output logic          clk_b_o,
    output logic          oe_a_o,
    output logic          oe_b_o
);

    localparam int CW    = XW + 2;
    localparam int NLANE = 2;

    logic [NUM_SRC-1:0] src_lvl;
    logic [NUM_SRC-1:0] src_rise;
    logic               sig;
    pair_sel_e          act_sel;
    logic               div_counting;
    logic               div_src_rise;
    logic               div_boundary;
    logic [CW-1:0]      div_cnt;
    logic [CW-1:0]      div_ratio;
    logic [NLANE-1:0]   lane_clk;
    logic [NLANE-1:0]   lane_oe;

    assign src_lvl[SRC_PLL] = pll_clk_i;
    assign src_lvl[SRC_REF] = ref_clk_i;

    clkpair_edge #(.NSRC(NUM_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (src_lvl),
        .rise_o (src_rise)
    );

    clkpair_div #(.XW(XW), .CW(CW)) u_div (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_sel_i      (pair_sel_e'(sel_i)),
        .cfg_from_ref_i (div_from_ref_i),
        .cfg_x_i        (x_ratio_i),
        .lvl_i          (src_lvl),
        .rise_i         (src_rise),
        .lock_i         (pll_lock_i),
        .sig_o          (sig),
        .act_sel_o      (act_sel),
        .counting_o     (div_counting),
        .src_rise_o     (div_src_rise),
        .boundary_o     (div_boundary),
        .cnt_o          (div_cnt),
        .ratio_o        (div_ratio)
    );

    clkpair_out #(.NLANE(NLANE)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_i     (sig),
        .inv_i     ({1'b0, invert_i}),
        .pair_en_i (pair_en_i),
        .en_i      ({en_b_i, en_a_i}),
        .clk_o     (lane_clk),
        .oe_o      (lane_oe)
    );

    assign clk_a_o = lane_clk[0];
    assign clk_b_o = lane_clk[1];
    assign oe_a_o  = lane_oe[0];
    assign oe_b_o  = lane_oe[1];

endmodule

// File: rtl/clkpair_gen_chk.sv
// Property checker for the clock pair generator, attached to the top by bind.
// Assumes: the signals between the divider core and the output stage are
// visible in the top-level scope.
module clkpair_gen_chk #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pll_lock_i,
    input logic          invert_i,
    input logic          pair_en_i,
    input logic          en_a_i,
    input logic          en_b_i,
    input logic          clk_a_o,
    input logic          clk_b_o,
    input logic          oe_a_o,
    input logic          oe_b_o,
    input logic [2:0]    act_sel,
    input logic          div_counting,
    input logic          div_src_rise,
    input logic          div_boundary,
    input logic [CW-1:0] div_cnt,
    input logic [CW-1:0] div_ratio
);

    localparam logic [2:0] LOCK_CODE = 3'b111;

    logic rst_prev_low;

    // Purpose: remember that reset was asserted at the previous edge
    always_ff @(posedge clk) begin
        rst_prev_low <= !rst_n;
    end

    // Purpose: after a reset edge every output is low
    always_ff @(posedge clk) begin
        if (rst_prev_low) begin
            assert_reset_quiet_R1: assert (!clk_a_o && !clk_b_o && !oe_a_o && !oe_b_o)
                else $error("outputs not quiet after reset edge");
        end
    end

    assert_divided_moves_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(div_counting) && $past(div_counting, 2)
         && (clk_b_o != $past(clk_b_o))) |-> $past(div_src_rise));

    assert_count_below_ratio_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < div_ratio);

    assert_lock_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(act_sel) == LOCK_CODE)) |->
        ((clk_b_o == $past(pll_lock_i)) && (clk_a_o == ($past(pll_lock_i) ^ $past(invert_i)))));

    assert_pair_polarity_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((clk_a_o ^ clk_b_o) == $past(invert_i)));

    assert_oe_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((oe_a_o == $past(pair_en_i & en_a_i)) && (oe_b_o == $past(pair_en_i & en_b_i))));

    assert_reload_at_terminal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (act_sel != $past(act_sel))) |-> $past(div_boundary));

endmodule

bind clkpair_gen clkpair_gen_chk #(.CW(XW + 2)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pll_lock_i   (pll_lock_i),
    .invert_i     (invert_i),
    .pair_en_i    (pair_en_i),
    .en_a_i       (en_a_i),
    .en_b_i       (en_b_i),
    .clk_a_o      (clk_a_o),
    .clk_b_o      (clk_b_o),
    .oe_a_o       (oe_a_o),
    .oe_b_o       (oe_b_o),
    .act_sel      (act_sel),
    .div_counting (div_counting),
    .div_src_rise (div_src_rise),
    .div_boundary (div_boundary),
    .div_cnt      (div_cnt),
    .div_ratio    (div_ratio)
);

// File: tb/clkpair_gen_bench.sv
// Bench for the clock pair generator: a behavioural per-cycle model built
// from the requirements, compared with the outputs after every core edge.
module clkpair_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pll_clk_i = 1'b0;
    logic       ref_clk_i = 1'b0;
    logic       pll_lock_i = 1'b0;
    logic [2:0] sel_i = 3'b010;
    logic       div_from_ref_i = 1'b0;
    logic [6:0] x_ratio_i = 7'd0;
    logic       invert_i = 1'b0;
    logic       pair_en_i = 1'b1;
    logic       en_a_i = 1'b1;
    logic       en_b_i = 1'b1;
    logic       clk_a_o, clk_b_o, oe_a_o, oe_b_o;

    clkpair_gen u_clkpair_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .pll_clk_i      (pll_clk_i),
        .ref_clk_i      (ref_clk_i),
        .pll_lock_i     (pll_lock_i),
        .sel_i          (sel_i),
        .div_from_ref_i (div_from_ref_i),
        .x_ratio_i      (x_ratio_i),
        .invert_i       (invert_i),
        .pair_en_i      (pair_en_i),
        .en_a_i         (en_a_i),
        .en_b_i         (en_b_i),
        .clk_a_o        (clk_a_o),
        .clk_b_o        (clk_b_o),
        .oe_a_o         (oe_a_o),
        .oe_b_o         (oe_b_o)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t      = 0;
    bit done   = 0;
    bit r9_window = 0;

    // model state
    int m_sel = 0, m_ref = 0, m_x = 0, m_cnt = 0, m_ppll = 0, m_pref = 0;
    int e_a = 0, e_b = 0, e_oea = 0, e_oeb = 0;
    string e_tag = "R1";
    string e_oetag = "R1";

    function automatic int ratio_of(input int sel, input int x);
        int xe;
        xe = (x < 2) ? 2 : x;
        case (sel)
            2: return 2;
            3: return 3;
            4: return 4;
            5: return xe + 3;
            6: return 2 * (xe + 3);
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Advance the model over the coming core edge, using the inputs now applied
    task automatic step_model();
        int pr, rr, sr, sl, n, s, nxt, cnting;
        if (!rst_n) begin
            m_sel = sel_i; m_ref = div_from_ref_i; m_x = x_ratio_i; m_cnt = 0;
            m_ppll = 0; m_pref = 0;
            e_a = 0; e_b = 0; e_oea = 0; e_oeb = 0;
            e_tag = "R1"; e_oetag = "R1";
            return;
        end
        pr = (pll_clk_i && !m_ppll) ? 1 : 0;
        rr = (ref_clk_i && !m_pref) ? 1 : 0;
        sr = m_ref ? rr : pr;
        sl = m_ref ? ref_clk_i : pll_clk_i;
        n = ratio_of(m_sel, m_x);
        cnting = (m_sel >= 2 && m_sel <= 6) ? 1 : 0;
        nxt = (m_cnt == n - 1) ? 0 : m_cnt + 1;
        case (m_sel)
            0: s = ref_clk_i;
            1: s = sl;
            7: s = pll_lock_i;
            default: s = (((sr != 0) ? nxt : m_cnt) < n / 2) ? 1 : 0;
        endcase
        if (r9_window)      e_tag = "R9";
        else if (invert_i)  e_tag = "R7";
        else case (m_sel)
            0: e_tag = "R2";
            1: e_tag = "R3";
            5, 6: e_tag = "R5";
            7: e_tag = "R6";
            default: e_tag = "R4";
        endcase
        e_oetag = "R8";
        if (!cnting || (sr != 0 && m_cnt == n - 1)) begin
            m_sel = sel_i; m_ref = div_from_ref_i; m_x = x_ratio_i; m_cnt = 0;
        end else if (sr != 0) begin
            m_cnt = nxt;
        end
        e_a = s ^ invert_i;
        e_b = s;
        e_oea = pair_en_i & en_a_i;
        e_oeb = pair_en_i & en_b_i;
        m_ppll = pll_clk_i;
        m_pref = ref_clk_i;
    endtask

    // Run n core cycles: drive source levels, step the model, compare at negedge
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            pll_clk_i = ((t / 2) % 2) != 0;
            ref_clk_i = ((t / 3) % 2) != 0;
            t++;
            step_model();
            @(negedge clk);
            cyc++;
            chk(e_tag, "clk_a_o", int'(clk_a_o), e_a);
            chk(e_tag, "clk_b_o", int'(clk_b_o), e_b);
            chk(e_oetag, "oe_a_o", int'(oe_a_o), e_oea);
            chk(e_oetag, "oe_b_o", int'(oe_b_o), e_oeb);
        end
    endtask

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        run(4);
        // R10: release with the sources low; first edge gives a high output
        rst_n = 1'b1; t = 0;
        run(1);
        chk("R10", "clk_b_o first edge after release", int'(clk_b_o), 1);
        run(40);
        // R4: fixed ratios
        sel_i = 3'b011; run(60);
        sel_i = 3'b100; div_from_ref_i = 1'b1; run(80);
        // R5: programmable ratios, including the clamp
        sel_i = 3'b101; x_ratio_i = 7'd0; run(80);
        x_ratio_i = 7'd1; run(40);
        x_ratio_i = 7'd10; div_from_ref_i = 1'b0; run(140);
        sel_i = 3'b110; x_ratio_i = 7'd3; div_from_ref_i = 1'b1; run(200);
        x_ratio_i = 7'd127; div_from_ref_i = 1'b0; run(2200);
        // R9: change mid-period; the old 2X period must finish first
        r9_window = 1; sel_i = 3'b010; run(1200); r9_window = 0;
        // R2: reference pass-through with PLL as divider source
        sel_i = 3'b000; div_from_ref_i = 1'b0; run(50);
        // R3: ratio 1 from each source
        sel_i = 3'b001; run(40);
        div_from_ref_i = 1'b1; run(40);
        // R6 and R7: lock indicator
        sel_i = 3'b111; pll_lock_i = 1'b0; run(10);
        pll_lock_i = 1'b1; run(10);
        invert_i = 1'b1; run(10);
        pll_lock_i = 1'b0; run(10);
        // R7: complementary divided pair
        sel_i = 3'b100; run(60);
        invert_i = 1'b0;
        // R8: enables; the clock keeps running while disabled
        pair_en_i = 1'b0; run(10);
        pair_en_i = 1'b1; en_a_i = 1'b0; run(10);
        en_a_i = 1'b1; en_b_i = 1'b0; run(10);
        en_b_i = 1'b1; run(5);
        // R1 and R10 again: reset in mid-run
        rst_n = 1'b0; run(3);
        sel_i = 3'b011; rst_n = 1'b1; t = 0;
        run(1);
        chk("R10", "clk_b_o after mid-run reset", int'(clk_b_o), 1);
        run(20);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion at cycle %0d", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule